// File: doc/BRIEF.md
# Two-Output Interrupt Aggregator

This block collects a set of level-sensitive interrupt request lines from peripherals. It combines them into two processor-facing requests: a normal request and a fast request. One source position is wired permanently to the fast request. Every other source can only raise the normal request. Each source is gated by a bit of an enable register, and software owns that register.

Software reaches the block through a small 32-bit register port made of an address, a write strobe, write data and read data. Two locations are decoded:

- **Offset 0x44, pending view.** It is read-only. It shows which sources are both asserted and enabled.
- **Offset 0x48, enable mask.** It is fully readable and writable.

Both request outputs are registered. They follow the source levels and the enable mask with a fixed latency of one clock. No edge memory is kept anywhere, so a request falls as soon as its source falls or is disabled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable mask reads 0xFFFEF7FF at offset 0x48 and both request outputs are low. In that state source 11 and source 16 alone raise no request.
- R2: A write to offset 0x48 replaces all 32 enable bits. A read of offset 0x48 returns the mask as written.
- R3: A read of offset 0x44 returns the source levels sampled at the last clock edge, ANDed bitwise with the enable mask.
- R4: The fast output is high exactly when source 8 was high at the previous clock edge and enable bit 8 is set.
- R5: The normal output is high exactly when at least one source other than 8 was high at the previous clock edge with its enable bit set. Source 8 never affects this output.
- R6: An enable write reaches the request outputs at the clock edge that stores it, which is the same one-cycle latency as a level change.
- R7: Writes to offset 0x44 leave the enable mask and the outputs unchanged.
- R8: Reads of any offset other than 0x44 and 0x48 return zero, and writes to such offsets are ignored.
- R9: Sources are not latched. A request drops one clock after its only active source drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Level-sensitive interrupt sources, one bit per source |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational from address and state) |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request (source 8 only) |

## Verification
The properties assume the following about the inputs:

- The source lines are synchronous to the clock.
- The address is held stable while the read data is being looked at.
- The write strobe is taken as one register update per cycle, with no handshake.
- Any bit pattern is legal on every source line, including source 8 toggling at will.

The stimulus satisfies these assumptions as follows. All inputs change only on the falling clock edge, and the address is held through the following rising edge. Writes are spread over the decoded offsets, unused offsets and the read-only offset, so the ignore-write properties are actually exercised rather than hold vacuously.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Which register the current bus address selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;

    // Registered request pair
    typedef struct packed {
        logic norm;
        logic fast;
    } irq_pair_t;

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    STAT_OFS = 8'h44,
    parameter logic [ADDR_W-1:0]    EN_OFS   = 8'h48
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == STAT_OFS) begin
            sel = SEL_STAT;
        end else if (addr == EN_OFS) begin
            sel = SEL_EN;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned           NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0]    EN_RESET = 32'hFFFE_F7FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  reg_sel_e           sel,
    input  logic               wr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] en_next,
    output logic [NUM_SRC-1:0] en_cur,
    output logic [NUM_SRC-1:0] rdata
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] lvl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = src_lvl;
        if (wr && (sel == SEL_EN)) begin
            st_d.en = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en  <= EN_RESET;
            st_q.lvl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_STAT: rdata = st_q.lvl & st_q.en;
            SEL_EN:   rdata = st_q.en;
            default:  rdata = '0;
        endcase
    end

    assign en_next = st_d.en;
    assign en_cur  = st_q.en;

endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned FAST_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_SRC-1:0] en,
    output logic               irq_norm,
    output logic               irq_fast
);

    logic [NUM_SRC-1:0] norm_vec;
    logic               fast_bit;
    irq_pair_t          out_d, out_q;

    // Per-source gating; the fast position is kept out of the normal tree
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == FAST_SRC) begin : g_fast
            assign norm_vec[i] = 1'b0;
            assign fast_bit    = src_lvl[i] & en[i];
        end else begin : g_norm
            assign norm_vec[i] = src_lvl[i] & en[i];
        end
    end

    always_comb begin
        out_d      = out_q;
        out_d.norm = |norm_vec;
        out_d.fast = fast_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_norm = out_q.norm;
    assign irq_fast = out_q.fast;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned          NUM_SRC  = 32,
    parameter int unsigned          FAST_SRC = 8,
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    STAT_OFS = 8'h44,
    parameter logic [ADDR_W-1:0]    EN_OFS   = 8'h48,
    parameter logic [NUM_SRC-1:0]   EN_RESET = 32'hFFFE_F7FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_norm,
    output logic               irq_fast
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] en_next;
    logic [NUM_SRC-1:0] en_q;

    irqagg_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .EN_OFS   (EN_OFS)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    irqagg_regs #(
        .NUM_SRC  (NUM_SRC),
        .EN_RESET (EN_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (src_lvl),
        .sel     (sel),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .en_next (en_next),
        .en_cur  (en_q),
        .rdata   (bus_rdata)
    );

    // Outputs are built from the post-write mask so a write lands with the level latency
    irqagg_route #(
        .NUM_SRC  (NUM_SRC),
        .FAST_SRC (FAST_SRC)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .en       (en_next),
        .irq_norm (irq_norm),
        .irq_fast (irq_fast)
    );

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int unsigned          NUM_SRC  = 32,
    parameter int unsigned          FAST_SRC = 8,
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    STAT_OFS = 8'h44,
    parameter logic [ADDR_W-1:0]    EN_OFS   = 8'h48,
    parameter logic [NUM_SRC-1:0]   EN_RESET = 32'hFFFE_F7FF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               irq_norm,
    input logic               irq_fast,
    input logic [NUM_SRC-1:0] en_q
);

    localparam logic [NUM_SRC-1:0] FAST_MASK = NUM_SRC'(1) << FAST_SRC;

    // R1
    reset_default_chk: assert property (@(posedge clk)
        !rst_n |=> (en_q == EN_RESET) && !irq_norm && !irq_fast);

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == EN_OFS) |=> en_q == $past(bus_wdata));

    // R3
    stat_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_OFS) |-> (bus_rdata & ~en_q) == '0);

    // R4
    fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_fast == ($past(src_lvl[FAST_SRC]) && en_q[FAST_SRC]));

    // R5
    norm_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_norm == (|($past(src_lvl) & en_q & ~FAST_MASK)));

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == EN_OFS) |=> $stable(en_q));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != STAT_OFS && bus_addr != EN_OFS) |-> bus_rdata == '0);

endmodule

bind irq_aggregator irqagg_chk #(
    .NUM_SRC  (NUM_SRC),
    .FAST_SRC (FAST_SRC),
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .EN_OFS   (EN_OFS),
    .EN_RESET (EN_RESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast),
    .en_q      (en_q)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

    localparam logic [7:0] A_STAT = 8'h44;
    localparam logic [7:0] A_EN   = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic [7:0]  bus_addr = A_EN;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;

    int checks = 0;
    int errors = 0;

    // Behavioural model state
    logic [31:0] m_en  = 32'hFFFE_F7FF;
    logic [31:0] m_lvl = '0;
    logic [7:0]  m_addr = A_EN;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    irq_aggregator dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl   (src_lvl),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_norm  (irq_norm),
        .irq_fast  (irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Drive one cycle at the falling edge, then compare everything at the next falling edge
    task automatic cyc(input logic [31:0] s, input logic [7:0] a, input logic w, input logic [31:0] d);
        logic [31:0] exp_rd;
        src_lvl   = s;
        bus_addr  = a;
        bus_wr    = w;
        bus_wdata = d;
        if (w && a == A_EN) m_en = d;
        m_lvl  = s;
        m_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R4 fast output", {31'd0, irq_fast}, {31'd0, m_lvl[8] & m_en[8]});
        chk("R5 normal output", {31'd0, irq_norm},
            {31'd0, ((m_lvl & m_en & ~32'h0000_0100) != 0)});
        if (m_addr == A_STAT) begin
            exp_rd = m_lvl & m_en;
            chk("R3 status read", bus_rdata, exp_rd);
        end else if (m_addr == A_EN) begin
            chk("R2 enable read", bus_rdata, m_en);
        end else begin
            chk("R8 unmapped read", bus_rdata, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values visible while reset is held
        chk("R1 reset enable", bus_rdata, 32'hFFFE_F7FF);
        chk("R1 reset outputs", {30'd0, irq_norm, irq_fast}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enable after release", bus_rdata, 32'hFFFE_F7FF);

        // R1: default-disabled sources 11 and 16
        cyc(32'h0000_0800, A_EN, 0, 0);
        chk("R1 src11 disabled", {31'd0, irq_norm}, 32'h0);
        cyc(32'h0001_0000, A_STAT, 0, 0);
        chk("R1 src16 disabled", {31'd0, irq_norm}, 32'h0);
        // R4 / R5 single sources
        cyc(32'h0000_0100, A_STAT, 0, 0);
        chk("R4 src8 fast only", {30'd0, irq_norm, irq_fast}, 32'h1);
        cyc(32'h0000_0001, A_STAT, 0, 0);
        chk("R5 src0 normal only", {30'd0, irq_norm, irq_fast}, 32'h2);

        // R6: mask writes land with one-cycle latency
        cyc(32'hFFFF_FFFF, A_EN, 1, 32'h0);
        chk("R6 mask cleared", {30'd0, irq_norm, irq_fast}, 32'h0);
        cyc(32'hFFFF_FFFF, A_EN, 1, 32'h0000_0100);
        chk("R6 fast enabled alone", {30'd0, irq_norm, irq_fast}, 32'h1);

        // R7: status offset is read-only
        cyc(32'hFFFF_FFFF, A_STAT, 1, 32'hFFFF_FFFF);
        cyc(32'hFFFF_FFFF, A_EN, 0, 0);
        chk("R7 status write ignored", bus_rdata, 32'h0000_0100);

        // R8: unmapped offsets
        cyc(32'h0, 8'h4C, 1, 32'hAAAA_5555);
        cyc(32'h0, A_EN, 0, 0);
        chk("R8 unmapped write ignored", bus_rdata, 32'h0000_0100);
        cyc(32'h0, 8'h00, 0, 0);
        chk("R8 offset 0 reads zero", bus_rdata, 32'h0);

        // R9: no latching
        cyc(32'hFFFF_FFFF, A_EN, 1, 32'hFFFF_FFFF);
        chk("R9 both high", {30'd0, irq_norm, irq_fast}, 32'h3);
        cyc(32'hFFFF_FEFF, A_EN, 0, 0);
        chk("R9 fast drops", {31'd0, irq_fast}, 32'h0);
        cyc(32'h0000_0100, A_EN, 0, 0);
        chk("R9 normal drops", {31'd0, irq_norm}, 32'h0);

        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [31:0] s, d;
            logic [7:0]  a;
            logic        w;
            rng = nxt(rng); s = rng;
            if (rng[3]) s = s & 32'h0000_0100;
            rng = nxt(rng); d = rng;
            case (rng[31:29])
                3'd0, 3'd1, 3'd2: a = A_STAT;
                3'd3, 3'd4:       a = A_EN;
                3'd5:             a = 8'h40;
                3'd6:             a = 8'h4C;
                default:          a = 8'h00;
            endcase
            w = rng[7] & rng[5];
            cyc(s, a, w, d);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule